// File: doc/BRIEF.md
# GPIO Interrupt Detector and Aggregator

This block watches a bank of 32 general-purpose input pins, grouped as four ports of eight, and turns pin activity into interrupt status. The pin levels arrive already synchronised to the block clock. Each pin can sense a rising edge, a falling edge, either edge, a high level or a low level. The sensing mode is held in a 24-bit word per port. A detected event sets a sticky status bit, and software removes that bit by writing a one to it.

Every pin also has an enable bit, which software changes with a masked write. Status bits that are enabled are ORed together across all four ports into a single registered bank interrupt. That interrupt feeds an upstream interrupt controller. Software then reads the status outputs to find which pin fired and clears it.

Top module: `gpio_irq_agg`

## Requirements
- R1: While rst_ni is low, every status bit, every enable bit, every sensing word and the bank interrupt are 0. The previous-sample register of every pin is also reset to 0.
- R2: The sensing word of a port is written as a whole: type_we_i=1 with type_port_i selecting the port and type_wdata_i giving the word. For pin i of that port, bit i is the polarity (1 = high or rising), bit 8+i is edge mode (1 = edge, 0 = level) and bit 16+i is both-edges. The codes, read as {bit16+i, bit8+i, bit i}, are: 011 rising, 010 falling, 110 both edges, 001 high level, 000 low level.
- R3: In edge mode a pin's status bit sets at the clock edge where the sampled level differs from the previous sample in the selected direction. With both-edges set, either direction sets it.
- R4: In level mode the status bit sets on every clock in which the pin sits at its active level. A clear therefore has no lasting effect while that level persists.
- R5: Status bits are sticky. A clear write (clr_we_i=1, clr_port_i, clr_wdata_i) removes each bit whose data bit is 1, and bits written 0 keep their value.
- R6: When an event and a clear hit the same status bit in the same clock, the bit stays set.
- R7: Status is recorded whether or not the pin's enable bit is 1.
- R8: An enable write (en_we_i=1, en_port_i) uses en_wdata_i[15:8] as a per-pin select and en_wdata_i[7:0] as the new values. Unselected enable bits keep their value.
- R9: irq_o is 1 exactly one clock after some status bit and its enable bit are both 1, in any port.
- R10: Writes and pin events act only on the port they address. Status bit 8*p+i belongs to port p, pin i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pin_i | input | 32 | Synchronised pin levels, bit 8*p+i is port p pin i |
| type_we_i | input | 1 | Sensing word write strobe |
| type_port_i | input | 2 | Port addressed by the sensing write |
| type_wdata_i | input | 24 | Sensing word: polarity, edge mode, both-edges planes |
| en_we_i | input | 1 | Enable masked-write strobe |
| en_port_i | input | 2 | Port addressed by the enable write |
| en_wdata_i | input | 16 | [15:8] pin select, [7:0] enable values |
| clr_we_i | input | 1 | Status clear strobe |
| clr_port_i | input | 2 | Port addressed by the clear |
| clr_wdata_i | input | 8 | Ones clear the matching status bits |
| status_o | output | 32 | Sticky interrupt status of all pins |
| irq_o | output | 1 | Registered bank interrupt |

## Verification
Two patterns are applied to one port under each of the five sensing codes: a half-overlapping pattern (0x0F to 0x33) and an alternating pattern (0xAA to 0x55). Across the codes they separate rising, falling, both-edge, high-level and low-level detection, and they show that a level still held after a clear re-sets its bit. A 0x00 to 0xFF and a 0xFF to 0x00 step confirm that the level modes capture the active level both before and after a clear. Directed cases on the other ports try a clear that arrives with an edge and a clear written with zeros. They also try selective enable writes and the one-clock lag of the interrupt, and they show that a pin on one port leaves the other ports' status untouched.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int unsigned PORT_W_DEF    = 8;
  localparam int unsigned NUM_PORTS_DEF = 4;

  // per-pin sensing code, {both, edge, pol}
  typedef struct packed {
    logic both;
    logic edge_mode;
    logic pol;
  } sense_t;
endpackage

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
(
  input  sense_t sense_i,
  input  logic   cur_i,
  input  logic   prev_i,
  output logic   hit_o
);
  logic rise, fall;

  always_comb begin
    rise = cur_i & ~prev_i;
    fall = ~cur_i & prev_i;
    if (sense_i.edge_mode) begin
      if (sense_i.both) hit_o = rise | fall;
      else              hit_o = sense_i.pol ? rise : fall;
    end else begin
      hit_o = (cur_i == sense_i.pol);
    end
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter  int unsigned PORT_W = PORT_W_DEF,
  localparam int unsigned TYPE_W = 3 * PORT_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PORT_W-1:0] pin_i,
  input  logic              type_we_i,
  input  logic [TYPE_W-1:0] type_wdata_i,
  input  logic              en_we_i,
  input  logic [2*PORT_W-1:0] en_wdata_i,
  input  logic              clr_we_i,
  input  logic [PORT_W-1:0] clr_wdata_i,
  output logic [PORT_W-1:0] status_o,
  output logic [PORT_W-1:0] enable_o,
  output logic [TYPE_W-1:0] type_o
);
  logic [TYPE_W-1:0] type_q;
  logic [PORT_W-1:0] en_q, prev_q, sta_q, hit, clr_mask, en_sel, en_val;

  assign en_sel   = en_wdata_i[2*PORT_W-1:PORT_W];
  assign en_val   = en_wdata_i[PORT_W-1:0];
  assign clr_mask = clr_we_i ? clr_wdata_i : '0;

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    sense_t sense;
    assign sense.pol       = type_q[i];
    assign sense.edge_mode = type_q[PORT_W+i];
    assign sense.both      = type_q[2*PORT_W+i];

    gpio_irq_detect u_det (
      .sense_i (sense),
      .cur_i   (pin_i[i]),
      .prev_i  (prev_q[i]),
      .hit_o   (hit[i])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      type_q <= '0;
      en_q   <= '0;
      prev_q <= '0;
      sta_q  <= '0;
    end else begin
      prev_q <= pin_i;
      // new event outranks a clear of the same bit
      sta_q  <= (sta_q & ~clr_mask) | hit;
      if (type_we_i) type_q <= type_wdata_i;
      if (en_we_i)   en_q   <= (en_q & ~en_sel) | (en_val & en_sel);
    end
  end

  assign status_o = sta_q;
  assign enable_o = en_q;
  assign type_o   = type_q;
endmodule

// File: rtl/gpio_irq_agg.sv
module gpio_irq_agg
  import gpio_irq_pkg::*;
#(
  parameter  int unsigned PORT_W    = PORT_W_DEF,
  parameter  int unsigned NUM_PORTS = NUM_PORTS_DEF,
  localparam int unsigned PIDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int unsigned PINS      = PORT_W * NUM_PORTS,
  localparam int unsigned TYPE_W    = 3 * PORT_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [PINS-1:0]     pin_i,
  input  logic                type_we_i,
  input  logic [PIDX_W-1:0]   type_port_i,
  input  logic [TYPE_W-1:0]   type_wdata_i,
  input  logic                en_we_i,
  input  logic [PIDX_W-1:0]   en_port_i,
  input  logic [2*PORT_W-1:0] en_wdata_i,
  input  logic                clr_we_i,
  input  logic [PIDX_W-1:0]   clr_port_i,
  input  logic [PORT_W-1:0]   clr_wdata_i,
  output logic [PINS-1:0]     status_o,
  output logic                irq_o
);
  logic [PINS-1:0]             en_all;
  logic [NUM_PORTS*TYPE_W-1:0] type_all;
  logic                        irq_q;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic type_we, en_we, clr_we;
    assign type_we = type_we_i && (type_port_i == PIDX_W'(p));
    assign en_we   = en_we_i   && (en_port_i   == PIDX_W'(p));
    assign clr_we  = clr_we_i  && (clr_port_i  == PIDX_W'(p));

    gpio_irq_port #(.PORT_W(PORT_W)) u_port (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .pin_i        (pin_i[p*PORT_W +: PORT_W]),
      .type_we_i    (type_we),
      .type_wdata_i (type_wdata_i),
      .en_we_i      (en_we),
      .en_wdata_i   (en_wdata_i),
      .clr_we_i     (clr_we),
      .clr_wdata_i  (clr_wdata_i),
      .status_o     (status_o[p*PORT_W +: PORT_W]),
      .enable_o     (en_all[p*PORT_W +: PORT_W]),
      .type_o       (type_all[p*TYPE_W +: TYPE_W])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_q <= 1'b0;
    else         irq_q <= |(status_o & en_all);
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/gpio_irq_agg_chk.sv
module gpio_irq_agg_chk #(
  parameter  int unsigned PORT_W    = 8,
  parameter  int unsigned NUM_PORTS = 4,
  localparam int unsigned PIDX_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1,
  localparam int unsigned PINS      = PORT_W * NUM_PORTS,
  localparam int unsigned TYPE_W    = 3 * PORT_W
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [PINS-1:0]             pin_i,
  input logic                        en_we_i,
  input logic [PIDX_W-1:0]           en_port_i,
  input logic [2*PORT_W-1:0]         en_wdata_i,
  input logic                        clr_we_i,
  input logic [PIDX_W-1:0]           clr_port_i,
  input logic [PORT_W-1:0]           clr_wdata_i,
  input logic [PINS-1:0]             status_o,
  input logic                        irq_o,
  input logic [PINS-1:0]             en_all,
  input logic [NUM_PORTS*TYPE_W-1:0] type_all
);
  logic [PINS-1:0] clr_vec, sel_vec, act_lvl;

  always_comb begin
    clr_vec = '0;
    sel_vec = '0;
    act_lvl = '0;
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (clr_we_i && clr_port_i == PIDX_W'(p))
        clr_vec[p*PORT_W +: PORT_W] = clr_wdata_i;
      if (en_we_i && en_port_i == PIDX_W'(p))
        sel_vec[p*PORT_W +: PORT_W] = en_wdata_i[2*PORT_W-1:PORT_W];
      for (int i = 0; i < PORT_W; i++) begin
        act_lvl[p*PORT_W+i] = !type_all[p*TYPE_W+PORT_W+i] &&
                              (pin_i[p*PORT_W+i] == type_all[p*TYPE_W+i]);
      end
    end
  end

  assert_reset_state_R1: assert property (@(posedge clk_i)
    !rst_ni |-> (status_o == '0 && !irq_o && en_all == '0 && type_all == '0));

  assert_sticky_status_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(status_o) & ~status_o) & ~$past(clr_vec)) == '0));

  assert_level_holds_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (($past(act_lvl) & ~status_o) == '0));

  assert_masked_enable_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((($past(en_all) ^ en_all) & ~$past(sel_vec)) == '0));

  assert_irq_latency_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (irq_o == $past(|(status_o & en_all))));
endmodule

bind gpio_irq_agg gpio_irq_agg_chk #(.PORT_W(PORT_W), .NUM_PORTS(NUM_PORTS)) u_chk (.*);

// File: tb/gpio_irq_agg_tb.sv
`timescale 1ns/1ps
module gpio_irq_agg_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] pin = '0;
  logic        type_we = 1'b0;
  logic [1:0]  type_port = '0;
  logic [23:0] type_wdata = '0;
  logic        en_we = 1'b0;
  logic [1:0]  en_port = '0;
  logic [15:0] en_wdata = '0;
  logic        clr_we = 1'b0;
  logic [1:0]  clr_port = '0;
  logic [7:0]  clr_wdata = '0;
  logic [31:0] status;
  logic        irq;

  int checks = 0;
  int errs   = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  gpio_irq_agg u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pin_i(pin),
    .type_we_i(type_we), .type_port_i(type_port), .type_wdata_i(type_wdata),
    .en_we_i(en_we), .en_port_i(en_port), .en_wdata_i(en_wdata),
    .clr_we_i(clr_we), .clr_port_i(clr_port), .clr_wdata_i(clr_wdata),
    .status_o(status), .irq_o(irq)
  );

  // {code, pins before, pins after, expected port-0 status}; code is {both,edge,pol}
  localparam logic [31:0] VEC [0:9] = '{
    32'h03_0F_33_30, 32'h02_0F_33_0C, 32'h06_0F_33_3C, 32'h01_0F_33_3F,
    32'h00_0F_33_FC, 32'h03_AA_55_55, 32'h02_AA_55_AA, 32'h06_AA_55_FF,
    32'h01_00_FF_FF, 32'h00_FF_00_FF
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic wr_type(input logic [1:0] p, input logic [23:0] w);
    type_we = 1'b1; type_port = p; type_wdata = w;
    tick();
    type_we = 1'b0;
  endtask

  task automatic wr_en(input logic [1:0] p, input logic [15:0] w);
    en_we = 1'b1; en_port = p; en_wdata = w;
    tick();
    en_we = 1'b0;
  endtask

  task automatic wr_clr(input logic [1:0] p, input logic [7:0] w);
    clr_we = 1'b1; clr_port = p; clr_wdata = w;
    tick();
    clr_we = 1'b0;
  endtask

  function automatic logic [23:0] plane(input logic [2:0] c);
    return {{8{c[2]}}, {8{c[1]}}, {8{c[0]}}};
  endfunction

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (3) tick();
    chk("R1 status in reset", status, 32'h0);
    chk("R1 irq in reset", {31'b0, irq}, 32'h0);
    rst_n = 1'b1;
    tick();
    // low-level default with pins low: all status set, nothing enabled
    chk("R7 status without enable", status, 32'hFFFF_FFFF);
    chk("R7 irq gated by enable", {31'b0, irq}, 32'h0);

    // R2 R3 R4: table on port 0
    for (int k = 0; k < 10; k++) begin
      wr_type(2'd0, plane(VEC[k][26:24]));
      pin[7:0] = VEC[k][23:16];
      tick(); tick();
      wr_clr(2'd0, 8'hFF);
      pin[7:0] = VEC[k][15:8];
      tick();
      chk($sformatf("R3/R4 vector %0d code %0h", k, VEC[k][26:24]),
          {24'h0, status[7:0]}, {24'h0, VEC[k][7:0]});
    end
    chk("R10 ports 1..3 untouched by port 0 table", {8'h0, status[31:8]}, 32'h00FF_FFFF);

    // R8 R9: masked enable on port 1, status bits 8 and 9 are set
    wr_en(2'd1, 16'h0303);
    chk("R9 irq lags enable by one clock", {31'b0, irq}, 32'h0);
    tick();
    chk("R9 irq after enable", {31'b0, irq}, 32'h1);
    wr_en(2'd1, 16'h0100);
    tick();
    chk("R8 unselected pin keeps enable", {31'b0, irq}, 32'h1);
    wr_en(2'd1, 16'h0200);
    tick();
    chk("R8 selected pin disabled", {31'b0, irq}, 32'h0);

    // R5 R10: rising mode on ports 1..3, clear all
    for (int p = 1; p < 4; p++) wr_type(2'(p), 24'h00FFFF);
    for (int p = 1; p < 4; p++) wr_clr(2'(p), 8'hFF);
    chk("R5 clear by ones", {8'h0, status[31:8]}, 32'h0);
    wr_en(2'd3, 16'h8080);
    pin[31] = 1'b1;
    tick();
    chk("R10 only port 3 pin 7 set", {8'h0, status[31:8]}, 32'h0080_0000);
    chk("R9 irq not yet", {31'b0, irq}, 32'h0);
    tick();
    chk("R9 irq from port 3", {31'b0, irq}, 32'h1);
    wr_clr(2'd3, 8'h7F);
    chk("R5 zero bits leave status", {31'b0, status[31]}, 32'h1);
    wr_clr(2'd3, 8'h80);
    chk("R5 one bit clears status", {31'b0, status[31]}, 32'h0);
    tick();
    chk("R9 irq drops after clear", {31'b0, irq}, 32'h0);

    // R6: edge and clear in the same clock on port 2 pin 5
    pin[21] = 1'b1;
    wr_clr(2'd2, 8'h20);
    chk("R6 event beats clear", {31'b0, status[21]}, 32'h1);

    // R4: high level on port 2, clear ineffective while high
    wr_type(2'd2, 24'h0000FF);
    wr_clr(2'd2, 8'hFF);
    chk("R4 level persists through clear", {24'h0, status[23:16]}, 32'h20);
    pin[21] = 1'b0;
    wr_clr(2'd2, 8'hFF);
    chk("R4 clear after level drops", {24'h0, status[23:16]}, 32'h0);

    // R3 falling on port 1 pin 0
    wr_type(2'd1, 24'h00FF00);
    wr_clr(2'd1, 8'hFF);
    pin[8] = 1'b1;
    tick();
    chk("R3 falling mode ignores rise", {24'h0, status[15:8]}, 32'h0);
    pin[8] = 1'b0;
    tick();
    chk("R3 falling mode catches fall", {24'h0, status[15:8]}, 32'h1);

    done = 1'b1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      summary();
      $finish;
    end
  end
endmodule